// File: doc/BRIEF.md
# Handshaked Parallel Byte Port

This block moves bytes between a processor register bus and an external device of unknown speed. There is no shared clock with the device. Each direction runs a four-phase handshake: idle, data ready, then data taken. The two channels are independent, and they swap roles.

On the inbound channel the device announces a byte with a strobe. The processor collects the byte by reading a data register, and the port acknowledges the device. On the outbound channel the processor writes a byte into a holding register. The port then raises a ready line toward the device, which acknowledges the byte.

The strobe and acknowledge lines from the device pass through a synchroniser before any state acts on them. A status register gives the processor three bits: inbound data available, outbound channel idle, and a sticky flag for rejected writes. Software polls this register.

Top module: `hs_pio_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x02: bit 0 (input available) is 0, bit 1 (output idle) is 1 and bit 2 (overflow) is 0. `out_rdy_o` and `in_ack_o` are both low.
- R2: A rising edge on `in_stb_i` while the input channel is idle latches `in_data_i`. It sets status bit 0 exactly three clock edges after the strobe rises, and not earlier.
- R3: A read of address 0 returns the latched byte, clears status bit 0 and raises `in_ack_o` at the same edge. `in_ack_o` stays high until the synchronised strobe is low, and then the channel returns to idle.
- R4: `bus_rdata_o` is zero and `bus_rdata_oe_o` is low whenever `bus_rd_i` is low. Reads of address 1 or address 3 return zero.
- R5: A write to address 1 while the output channel is idle captures the byte on `out_data_o`. From the next edge it raises `out_rdy_o` and clears status bit 1.
- R6: A synchronised rising edge on `out_ack_i` drops `out_rdy_o`. Status bit 1 returns to 1 only after the synchronised acknowledge is low again.
- R7: A write to address 1 while the output channel is not idle is ignored: `out_data_o` keeps its value and status bit 2 becomes 1.
- R8: Status bit 2 stays set until a write to address 2 with data bit 2 set. A write to address 2 with bit 2 clear leaves it set.
- R9: A strobe rising edge while the input channel is not idle is ignored, and the byte latched earlier is still the one read back.
- R10: An acknowledge edge while the output channel is idle has no effect: `out_rdy_o` stays low and status bit 1 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address: 0 input data, 1 output data, 2 status |
| bus_rd_i | input | 1 | Read access this cycle |
| bus_wr_i | input | 1 | Write access this cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, zero outside a read |
| bus_rdata_oe_o | output | 1 | Read data drive enable |
| in_data_i | input | DATA_W | Byte from device |
| in_stb_i | input | 1 | Device strobe: inbound data ready |
| in_ack_o | output | 1 | Port acknowledge: inbound data taken |
| out_data_o | output | DATA_W | Held outbound byte |
| out_rdy_o | output | 1 | Port strobe: outbound data ready |
| out_ack_i | input | 1 | Device acknowledge: outbound data taken |

## Verification
The bench builds the port with an 8-bit data path and a two-stage synchroniser. This fixes the latency from a device edge to a state change at three clock edges, which the bench checks cycle by cycle on the inbound channel. Byte patterns such as 0xA5, 0x5A, 0xC3 and 0x7E toggle every data bit in both directions. The 8-bit width also leaves room for all three status bits, so the bench can check the rejected-write flag and its clear.

// File: rtl/hs_pio_pkg.sv
package hs_pio_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READY = 2'd1,
    PH_TAKEN = 2'd2
  } phase_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_IN   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_OUT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int ST_IN_AVAIL = 0;
  localparam int ST_OUT_IDLE = 1;
  localparam int ST_OVF      = 2;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan
  import hs_pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_lvl_i,
  input  logic              stb_rise_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              avail_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o
);
  phase_e            st_q, st_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE:  if (stb_rise_i) st_d = PH_READY;
      PH_READY: if (take_i)     st_d = PH_TAKEN;
      PH_TAKEN: if (!stb_lvl_i) st_d = PH_IDLE;
      default:                  st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      // capture only on the idle->ready step; later strobes are dropped
      if (st_q == PH_IDLE && stb_rise_i) data_q <= data_i;
    end
  end

  assign avail_o = (st_q == PH_READY);
  assign ack_o   = (st_q == PH_TAKEN);
  assign data_o  = data_q;
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan
  import hs_pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_lvl_i,
  input  logic              ack_rise_i,
  output logic              idle_o,
  output logic              rdy_o,
  output logic              reject_o,
  output logic [DATA_W-1:0] data_o
);
  phase_e            st_q, st_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE:  if (wr_i)       st_d = PH_READY;
      PH_READY: if (ack_rise_i) st_d = PH_TAKEN;
      PH_TAKEN: if (!ack_lvl_i) st_d = PH_IDLE;
      default:                  st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == PH_IDLE && wr_i) hold_q <= wdata_i;
    end
  end

  assign idle_o   = (st_q == PH_IDLE);
  assign rdy_o    = (st_q == PH_READY);
  assign reject_o = wr_i && (st_q != PH_IDLE);
  assign data_o   = hold_q;
endmodule

// File: rtl/hs_pio_port.sv
module hs_pio_port
  import hs_pio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rdata_oe_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_stb_i,
  output logic              in_ack_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_rdy_o,
  input  logic              out_ack_i
);
  logic stb_lvl, stb_rise, ack_lvl, ack_rise;
  logic in_avail, out_idle, out_reject, ovf_q;
  logic rd_in, wr_out, wr_stat;
  logic [DATA_W-1:0] in_byte, status;

  assign rd_in   = bus_rd_i && (bus_addr_i == ADDR_IN);
  assign wr_out  = bus_wr_i && (bus_addr_i == ADDR_OUT);
  assign wr_stat = bus_wr_i && (bus_addr_i == ADDR_STAT);

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
    .clk_i, .rst_ni, .d_i(in_stb_i), .lvl_o(stb_lvl), .rise_o(stb_rise)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i, .rst_ni, .d_i(out_ack_i), .lvl_o(ack_lvl), .rise_o(ack_rise)
  );

  hs_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk_i, .rst_ni,
    .stb_lvl_i (stb_lvl),
    .stb_rise_i(stb_rise),
    .data_i    (in_data_i),
    .take_i    (rd_in),
    .avail_o   (in_avail),
    .ack_o     (in_ack_o),
    .data_o    (in_byte)
  );

  hs_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .wr_i      (wr_out),
    .wdata_i   (bus_wdata_i),
    .ack_lvl_i (ack_lvl),
    .ack_rise_i(ack_rise),
    .idle_o    (out_idle),
    .rdy_o     (out_rdy_o),
    .reject_o  (out_reject),
    .data_o    (out_data_o)
  );

  // sticky rejected-write flag, write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ovf_q <= 1'b0;
    else if (out_reject)                    ovf_q <= 1'b1;
    else if (wr_stat && bus_wdata_i[ST_OVF]) ovf_q <= 1'b0;
  end

  always_comb begin
    status              = '0;
    status[ST_IN_AVAIL] = in_avail;
    status[ST_OUT_IDLE] = out_idle;
    status[ST_OVF]      = ovf_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (bus_addr_i)
        ADDR_IN:   bus_rdata_o = in_byte;
        ADDR_STAT: bus_rdata_o = status;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign bus_rdata_oe_o = bus_rd_i;
endmodule

// File: rtl/hs_pio_port_chk.sv
module hs_pio_port_chk
  import hs_pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              bus_rdata_oe_o,
  input logic              in_ack_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_rdy_o,
  input logic              out_idle,
  input logic              ovf_q
);
  a_r3_ack_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(bus_rd_i && bus_addr_i == ADDR_IN));

  a_r4_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> (bus_rdata_o == '0 && !bus_rdata_oe_o));

  a_r5_write_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_OUT && out_idle)
      |=> (out_rdy_o && out_data_o == $past(bus_wdata_i)));

  a_r6_drop_not_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_rdy_o) |-> !out_idle);

  a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_idle |=> $stable(out_data_o));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(bus_wr_i && bus_addr_i == ADDR_STAT && bus_wdata_i[ST_OVF])) |=> ovf_q);
endmodule

bind hs_pio_port hs_pio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_addr_i    (bus_addr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_wr_i      (bus_wr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .bus_rdata_oe_o(bus_rdata_oe_o),
  .in_ack_o      (in_ack_o),
  .out_data_o    (out_data_o),
  .out_rdy_o     (out_rdy_o),
  .out_idle      (out_idle),
  .ovf_q         (ovf_q)
);

// File: tb/tb_hs_pio_port.sv
`timescale 1ns/1ps
module tb_hs_pio_port;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    bus_addr_i = '0;
  logic          bus_rd_i = 1'b0;
  logic          bus_wr_i = 1'b0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic [DW-1:0] bus_rdata_o;
  logic          bus_rdata_oe_o;
  logic [DW-1:0] in_data_i = '0;
  logic          in_stb_i = 1'b0;
  logic          in_ack_o;
  logic [DW-1:0] out_data_o;
  logic          out_rdy_o;
  logic          out_ack_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  hs_pio_port #(.DATA_W(DW), .SYNC_STAGES(2)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // driver: one read cycle, expected data goes to the scoreboard
  task automatic bus_read(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back('{val: e, tag: tag});
    bus_addr_i = a;
    bus_rd_i   = 1'b1;
    step(1);
    bus_rd_i   = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_wr_i    = 1'b1;
    step(1);
    bus_wr_i    = 1'b0;
  endtask

  // monitor: compares read data mid-cycle
  always @(negedge clk_i) begin
    if (bus_rd_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: actual=0x%0h expected=none", bus_rdata_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " rdata"}, bus_rdata_o, e.val);
        check({e.tag, " oe"}, bus_rdata_oe_o, 1'b1);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state, R4 quiet bus
    check("R1 out_rdy", out_rdy_o, 1'b0);
    check("R1 in_ack", in_ack_o, 1'b0);
    check("R4 idle rdata", bus_rdata_o, 8'h00);
    check("R4 idle oe", bus_rdata_oe_o, 1'b0);
    bus_read(2'd2, 8'h02, "R1 status");

    // R2 exact latency: strobe set after edge P0
    in_data_i = 8'hA5;
    in_stb_i  = 1'b1;
    step(2);
    bus_read(2'd2, 8'h02, "R2 not yet");
    bus_read(2'd2, 8'h03, "R2 avail");

    // R9 second strobe while full is dropped
    in_stb_i = 1'b0;
    step(4);
    in_data_i = 8'h3C;
    in_stb_i  = 1'b1;
    step(4);
    bus_read(2'd0, 8'hA5, "R9 R3 first byte kept");
    check("R3 ack raised", in_ack_o, 1'b1);
    bus_read(2'd2, 8'h02, "R3 avail cleared");
    step(4);
    check("R3 ack held", in_ack_o, 1'b1);
    in_stb_i = 1'b0;
    step(4);
    check("R3 ack released", in_ack_o, 1'b0);
    check("R4 quiet rdata", bus_rdata_o, 8'h00);

    // R2 second full inbound transfer
    in_data_i = 8'h5A;
    in_stb_i  = 1'b1;
    step(4);
    in_data_i = 8'hFF;
    bus_read(2'd0, 8'h5A, "R2 second byte");
    in_stb_i = 1'b0;
    step(4);
    check("R3 back idle", in_ack_o, 1'b0);

    // R5 outbound launch
    bus_write(2'd1, 8'hC3);
    check("R5 rdy", out_rdy_o, 1'b1);
    check("R5 data", out_data_o, 8'hC3);
    bus_read(2'd2, 8'h00, "R5 status busy");

    // R7 write while ready
    bus_write(2'd1, 8'h11);
    check("R7 data kept", out_data_o, 8'hC3);
    bus_read(2'd2, 8'h04, "R7 ovf set");

    // R6 ack rising
    out_ack_i = 1'b1;
    step(4);
    check("R6 rdy dropped", out_rdy_o, 1'b0);
    bus_read(2'd2, 8'h04, "R6 still busy");
    bus_write(2'd1, 8'h22);
    check("R7 data kept taken", out_data_o, 8'hC3);
    out_ack_i = 1'b0;
    step(4);
    bus_read(2'd2, 8'h06, "R6 idle again");

    // R8 clear semantics
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, 8'h06, "R8 zero keeps");
    bus_write(2'd2, 8'h04);
    bus_read(2'd2, 8'h02, "R8 one clears");

    // R10 ack while idle
    out_ack_i = 1'b1;
    step(4);
    check("R10 rdy low", out_rdy_o, 1'b0);
    bus_read(2'd2, 8'h02, "R10 idle kept");
    out_ack_i = 1'b0;
    step(4);

    // R5 second outbound transfer
    bus_write(2'd1, 8'h7E);
    check("R5 second data", out_data_o, 8'h7E);
    check("R5 second rdy", out_rdy_o, 1'b1);
    out_ack_i = 1'b1;
    step(4);
    check("R6 second drop", out_rdy_o, 1'b0);
    out_ack_i = 1'b0;
    step(4);
    bus_read(2'd2, 8'h02, "R6 second idle");

    // R4 unused addresses
    bus_read(2'd1, 8'h00, "R4 addr1");
    bus_read(2'd3, 8'h00, "R4 addr3");
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule